// File: doc/BRIEF.md
# Overflow-Quantized Interval Timer

This block raises a periodic "interval elapsed" indication for a processor. Software hands it an interval expressed in raw reference-oscillator ticks. The timer does not count those ticks itself. It counts overflow strobes from an external 12-bit prescaler, so it first rounds the requested tick count up to a whole number of prescaler overflows. That rounded number is the period. Each time the period elapses, a sticky done flag is set, the overflow count starts again from zero, and the next period begins.

A write made while an interval is running only stages the new period. The running interval completes with its old length, and the staged value takes over at the expiry. The prescaler keeps running across writes, so the first expiry after a write can arrive up to one prescaler period later than the written tick count would suggest. When the timer is idle because its period is zero, a nonzero write starts counting at once. A read returns the interval word as it was written, apart from the top bit, and not the rounded period.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset the done flag is 0, the read port returns 0 and the timer is idle, with period zero.
- R2: For a written word v, the period in overflow strobes is v[34:12] plus one if any bit of v[11:0] is 1. The done flag first rises after exactly that many strobes.
- R3: Bit 35 of a written word has no effect on the period and always reads back as 0.
- R4: The read port returns the last written word with bit 35 cleared. It does not return the rounded period.
- R5: The overflow count advances only on cycles where the strobe is high. Without strobes no expiry occurs, however many cycles pass.
- R6: The done flag stays at 1 until flag_clr is asserted. If an expiry and flag_clr fall in the same cycle, the flag stays at 1.
- R7: A write made while a nonzero period is running replaces neither the running period nor the count. The running interval expires on its old length, and the new period applies from the following interval.
- R8: A nonzero write made while the timer is idle loads the period at once, with the count starting at zero.
- R9: While the period is zero, no expiry occurs.
- R10: On each expiry the count restarts from zero, so expiries repeat every period strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the interval word |
| wr_data | input | 36 | Interval in reference ticks |
| rd_data | output | 36 | Last written interval word, bit 35 zero |
| ovf_strobe | input | 1 | One-cycle prescaler overflow pulse |
| flag_clr | input | 1 | Clears the done flag |
| done_flag | output | 1 | Sticky interval-elapsed flag |

## Verification
The hardest case to reach from the ports is a write that arrives in the middle of a running interval. Its effect shows only one expiry later, because the period being counted is internal state. The bench starts a long period and lets part of it elapse with a few strobes. It then writes a much shorter value and counts the strobes up to the next rise of the flag, which must match the remainder of the old period. It then counts the strobes up to the following rise, which must match the new period. A sweep over several whole-unit counts, each combined with several patterns in the low 12 bits, covers the rounding, including the zero period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Default geometry of the interval word and the prescaler
  localparam int unsigned DEF_WORD_W  = 36;
  localparam int unsigned DEF_PRESC_W = 12;
endpackage

// File: rtl/tmr_interval_regs.sv
module tmr_interval_regs #(
  parameter int unsigned WORD_W  = tmr_pkg::DEF_WORD_W,
  parameter int unsigned PRESC_W = tmr_pkg::DEF_PRESC_W,
  localparam int unsigned PER_W  = WORD_W - PRESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q,
  output logic [PER_W-1:0]  rounded,
  output logic [PER_W-1:0]  pending_q
);
  // Whole prescaler units, plus one unit if any sub-unit bit is set.
  // The top (sign) bit is excluded from the count.
  function automatic logic [PER_W-1:0] round_units(input logic [WORD_W-1:0] w);
    logic [PER_W-1:0] whole;
    logic             frac;
    whole = {1'b0, w[WORD_W-2:PRESC_W]};
    frac  = |w[PRESC_W-1:0];
    return whole + {{(PER_W-1){1'b0}}, frac};
  endfunction

  assign rounded = round_units(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= '0;
      pending_q <= '0;
    end else if (wr_en) begin
      word_q    <= {1'b0, wr_data[WORD_W-2:0]};
      pending_q <= rounded;
    end
  end
endmodule

// File: rtl/tmr_period_counter.sv
module tmr_period_counter #(
  parameter int unsigned PER_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_strobe,
  input  logic             wr_en,
  input  logic [PER_W-1:0] rounded,
  input  logic [PER_W-1:0] pending_q,
  output logic [PER_W-1:0] active_q,
  output logic [PER_W-1:0] count_q,
  output logic             expire,
  output logic             idle
);
  logic [PER_W-1:0] count_nx;
  logic [PER_W-1:0] next_period;

  assign idle        = (active_q == '0);
  assign count_nx    = count_q + {{(PER_W-1){1'b0}}, 1'b1};
  assign expire      = ovf_strobe && !idle && (count_nx == active_q);
  // A write in the expiry cycle is not lost: it becomes the next period.
  assign next_period = wr_en ? rounded : pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      count_q  <= '0;
    end else if (idle) begin
      count_q <= '0;
      if (wr_en) active_q <= rounded;
    end else if (expire) begin
      count_q  <= '0;
      active_q <= next_period;
    end else if (ovf_strobe) begin
      count_q <= count_nx;
    end
  end
endmodule

// File: rtl/tmr_done_latch.sv
module tmr_done_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag_q
);
  // Setting wins over clearing so that no expiry is lost.
  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_evt) flag_q <= 1'b0;
  end
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer #(
  parameter int unsigned WORD_W  = tmr_pkg::DEF_WORD_W,
  parameter int unsigned PRESC_W = tmr_pkg::DEF_PRESC_W,
  localparam int unsigned PER_W  = WORD_W - PRESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ovf_strobe,
  input  logic              flag_clr,
  output logic              done_flag
);
  // Internal events brought out as named wires for the checker
  logic [PER_W-1:0] rounded;
  logic [PER_W-1:0] pending_q;
  logic [PER_W-1:0] active_q;
  logic [PER_W-1:0] count_q;
  logic             expire_evt;
  logic             idle;

  tmr_interval_regs #(.WORD_W(WORD_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .word_q(rd_data), .rounded(rounded), .pending_q(pending_q)
  );

  tmr_period_counter #(.PER_W(PER_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ovf_strobe(ovf_strobe), .wr_en(wr_en),
    .rounded(rounded), .pending_q(pending_q), .active_q(active_q),
    .count_q(count_q), .expire(expire_evt), .idle(idle)
  );

  tmr_done_latch u_done (
    .clk(clk), .rst_n(rst_n), .set_evt(expire_evt), .clr_evt(flag_clr),
    .flag_q(done_flag)
  );
endmodule

// File: rtl/tick_interval_timer_chk.sv
module tick_interval_timer_chk #(
  parameter int unsigned WORD_W = 36,
  parameter int unsigned PER_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              ovf_strobe,
  input logic              flag_clr,
  input logic              done_flag,
  input logic              expire_evt,
  input logic [PER_W-1:0]  active_q,
  input logic [PER_W-1:0]  count_q
);
  // R6
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> done_flag);
  // R5
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_strobe |=> !$rose(done_flag));
  // R4
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == {1'b0, $past(wr_data[WORD_W-2:0])});
  // R3
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1] == 1'b0);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != '0) |-> (count_q < active_q));
  // R7
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire_evt && !(wr_en && active_q == '0)) |=> $stable(active_q));
  // R9
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> !expire_evt);
endmodule

bind tick_interval_timer tick_interval_timer_chk #(.WORD_W(WORD_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .ovf_strobe(ovf_strobe), .flag_clr(flag_clr),
  .done_flag(done_flag), .expire_evt(expire_evt), .active_q(active_q),
  .count_q(count_q)
);

// File: tb/test_tick_interval_timer.sv
module test_tick_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        ovf_strobe = 1'b0;
  logic        flag_clr = 1'b0;
  logic        done_flag;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  tick_interval_timer i_tick_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ovf_strobe(ovf_strobe), .flag_clr(flag_clr),
    .done_flag(done_flag)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic write_word(input logic [35:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic clr);
    @(negedge clk); ovf_strobe = 1'b1; flag_clr = clr;
    @(negedge clk); ovf_strobe = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  // Strobes until the flag rises; returns the count, or 0 if none within lim
  task automatic strobes_to_done(input int lim, output int n);
    n = 0;
    for (int k = 1; k <= lim; k++) begin
      pulse(1'b0);
      if (done_flag && n == 0) n = k;
      if (n != 0) break;
    end
  endtask

  function automatic int expect_units(input logic [35:0] v);
    int u;
    u = int'(v[34:12]);
    if (v[11:0] != 12'd0) u = u + 1;
    return u;
  endfunction

  initial begin
    int n;
    logic [35:0] v;
    logic [11:0] lows [4];
    lows[0] = 12'h000; lows[1] = 12'h001; lows[2] = 12'h800; lows[3] = 12'hFFF;

    do_reset();
    // R1 reset state
    check("R1 done", {35'd0, done_flag}, 36'd0);
    check("R1 rd", rd_data, 36'd0);
    // R9 / R1 idle after reset: no expiry
    strobes_to_done(8, n);
    check("R9 idle after reset", 36'(n), 36'd0);

    // R2 sweep: units x low patterns, also R8 (start from idle)
    for (int u = 0; u < 6; u++) begin
      for (int l = 0; l < 4; l++) begin
        do_reset();
        v = {1'b0, 23'(u), lows[l]};
        write_word(v);
        strobes_to_done(10, n);
        check("R2 rounding / R8 idle start", 36'(n), 36'(expect_units(v)));
        check("R4 readback", rd_data, v);
      end
    end

    // R3 top bit ignored and reads as zero
    do_reset();
    write_word(36'h8_0000_2000);
    check("R3 rd top bit", rd_data, 36'h0_0000_2000);
    strobes_to_done(8, n);
    check("R3 period", 36'(n), 36'd2);

    // R9 zero period with top bit set
    do_reset();
    write_word(36'h8_0000_0000);
    strobes_to_done(8, n);
    check("R9 zero period", 36'(n), 36'd0);

    // R5 no strobes, no expiry
    do_reset();
    write_word(36'h0_0000_1000);
    repeat (20) @(negedge clk);
    check("R5 no strobe", {35'd0, done_flag}, 36'd0);
    pulse(1'b0);
    check("R5 single strobe", {35'd0, done_flag}, 36'd1);

    // R6 sticky and set-wins
    repeat (10) @(negedge clk);
    check("R6 sticky", {35'd0, done_flag}, 36'd1);
    pulse(1'b1);   // expiry and clear in same cycle (period 1)
    check("R6 set wins", {35'd0, done_flag}, 36'd1);
    clear_flag();
    check("R6 clear", {35'd0, done_flag}, 36'd0);

    // R10 periodic reload every 3 strobes
    do_reset();
    write_word(36'h0_0000_2ABC);
    for (int r = 0; r < 3; r++) begin
      strobes_to_done(10, n);
      check("R10 repeat", 36'(n), 36'd3);
      clear_flag();
    end

    // R7 write mid-interval: old period completes, new one next
    do_reset();
    write_word(36'h0_0000_5000);   // 5 units
    pulse(1'b0); pulse(1'b0);       // 2 of 5 used
    write_word(36'h0_0000_1000);   // 1 unit, pending
    check("R7 rd new word", rd_data, 36'h0_0000_1000);
    strobes_to_done(10, n);
    check("R7 old completes", 36'(n), 36'd3);
    clear_flag();
    strobes_to_done(10, n);
    check("R7 new applies", 36'(n), 36'd1);
    clear_flag();

    // R7 write of zero mid-interval stops after current interval
    write_word(36'h0);
    strobes_to_done(10, n);
    check("R7 last old interval", 36'(n), 36'd1);
    clear_flag();
    strobes_to_done(8, n);
    check("R9 stopped", 36'(n), 36'd0);

    finished = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule